// File: doc/BRIEF.md
# Dual-output banked interrupt controller

This block gathers 96 level-sensitive interrupt sources into three banks of 32 bits. A high input sets a sticky pending bit. That bit stays set until software clears it through the register port. A per-source mask decides which pending sources reach the normal interrupt line. A per-source select bit also routes an unmasked pending source to a second, fast interrupt line. Both lines are registered.

Software reaches the block through a plain 32-bit register port. The port has a write strobe, a 10-bit byte offset inside a 1 KB window, write data and a combinational read-data output. The two low offset bits are ignored. Vector numbering, priority resolution and nesting are left to the processor.

Top module: `banked_irq_ctl`

## Requirements
- R1: Source n maps to bank n/32, bit n%32. Offset bits 3:2 pick the bank inside a register group: bank 0 at +0x0, bank 1 at +0x4, bank 2 at +0x8. The groups are: pending at 0x10, fast-pending at 0x20, select at 0x30, enable at 0x40, mask at 0x50. The single registers are: vector at 0x00, base at 0x04, protect at 0x08, nmi at 0x0C.
- R2: A source input sampled high at a clock edge sets its pending bit. The bit stays set after the input goes low.
- R3: Writing a pending register clears each bit written as 1 and keeps each bit written as 0. If a source is high in the same cycle as the clearing write, its bit stays set.
- R4: `irq_o` is high when any source is pending and its mask bit is 0. It changes at the same clock edge that updates the pending or mask state.
- R5: `fiq_o` is high when any source is pending, unmasked and selected. It follows the same timing as `irq_o`.
- R6: The select, enable, mask, protect and nmi registers read back the value last written. Enable has no effect on either output.
- R7: A write to the vector or base register stores the data with bits 1:0 forced to 0.
- R8: The fast-pending bank is write-1-to-clear. No source sets it, so it always reads 0.
- R9: Offsets 0x60 and above, and bank index 3 (+0xC) inside groups 0x10 to 0x50, read as 0. Writes to those offsets change no register.
- R10: Reset clears every register and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 96 | Level interrupt sources |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Byte offset in the register window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt, registered |
| fiq_o | output | 1 | Fast interrupt, registered |

## Verification
Register contents and read data are combinational from the offset, so a read is sampled 1 ns after the offset is driven. Pending bits, stored registers and both outputs all change at the first rising edge after a source rises or a write is presented. The bench therefore drives every stimulus on a falling edge and checks the result on the next falling edge, half a cycle after that capturing edge. Stickiness and the set-over-clear rule are checked several cycles later to show the state holds.

// File: rtl/banked_irq_ctl.sv
module banked_irq_ctl #(
  parameter int BANKS = 3,
  parameter int AW    = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BANKS*32-1:0]   src_i,
  input  logic                  reg_wr_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  output logic                  irq_o,
  output logic                  fiq_o
);
  localparam int NSRC = BANKS * 32;
  localparam int GW   = AW - 4;

  wire [GW-1:0] grp = reg_addr_i[AW-1:4];
  wire [1:0]    idx = reg_addr_i[3:2];

  logic [31:0] vec_q, base_q, prot_q, nmi_q;
  logic [31:0] pend_q [BANKS];
  logic [31:0] fpnd_q [BANKS];
  logic [31:0] sel_q  [BANKS];
  logic [31:0] en_q   [BANKS];
  logic [31:0] msk_q  [BANKS];
  logic [NSRC-1:0] pend_all, msk_all, sel_all;
  logic [BANKS-1:0] irq_b, fiq_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0; base_q <= '0; prot_q <= '0; nmi_q <= '0;
    end else if (reg_wr_i && grp == '0) begin
      case (idx)
        2'd0: vec_q  <= reg_wdata_i & ~32'h3;
        2'd1: base_q <= reg_wdata_i & ~32'h3;
        2'd2: prot_q <= reg_wdata_i;
        default: nmi_q <= reg_wdata_i;
      endcase
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    wire         hit   = reg_wr_i && (idx == 2'(b));
    wire  [31:0] clr_p = (hit && grp == GW'(1)) ? reg_wdata_i : '0;
    wire  [31:0] clr_f = (hit && grp == GW'(2)) ? reg_wdata_i : '0;
    wire  [31:0] pend_n = (pend_q[b] & ~clr_p) | src_i[b*32 +: 32];
    wire  [31:0] sel_n  = (hit && grp == GW'(3)) ? reg_wdata_i : sel_q[b];
    wire  [31:0] msk_n  = (hit && grp == GW'(5)) ? reg_wdata_i : msk_q[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[b] <= '0; fpnd_q[b] <= '0; sel_q[b] <= '0;
        en_q[b]   <= '0; msk_q[b]  <= '0;
      end else begin
        pend_q[b] <= pend_n;
        fpnd_q[b] <= fpnd_q[b] & ~clr_f;
        sel_q[b]  <= sel_n;
        msk_q[b]  <= msk_n;
        if (hit && grp == GW'(4)) en_q[b] <= reg_wdata_i;
      end
    end

    assign irq_b[b] = |(pend_n & ~msk_n);
    assign fiq_b[b] = |(pend_n & ~msk_n & sel_n);
    assign pend_all[b*32 +: 32] = pend_q[b];
    assign msk_all[b*32 +: 32]  = msk_q[b];
    assign sel_all[b*32 +: 32]  = sel_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_b;
      fiq_o <= |fiq_b;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (grp == '0) begin
      case (idx)
        2'd0: reg_rdata_o = vec_q;
        2'd1: reg_rdata_o = base_q;
        2'd2: reg_rdata_o = prot_q;
        default: reg_rdata_o = nmi_q;
      endcase
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (idx == 2'(b)) begin
          case (grp)
            GW'(1): reg_rdata_o = pend_q[b];
            GW'(2): reg_rdata_o = fpnd_q[b];
            GW'(3): reg_rdata_o = sel_q[b];
            GW'(4): reg_rdata_o = en_q[b];
            GW'(5): reg_rdata_o = msk_q[b];
            default: reg_rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/banked_irq_ctl_chk.sv
module banked_irq_ctl_chk #(
  parameter int BANKS = 3,
  parameter int AW    = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic [BANKS*32-1:0] src_i,
  input logic                reg_wr_i,
  input logic [AW-1:0]       reg_addr_i,
  input logic [31:0]         reg_rdata_o,
  input logic                irq_o,
  input logic                fiq_o,
  input logic [BANKS*32-1:0] pend_all,
  input logic [BANKS*32-1:0] msk_all,
  input logic [BANKS*32-1:0] sel_all
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_i) |=> ((pend_all & $past(src_i)) == $past(src_i)));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i[AW-1:4] == (AW-4)'(1))
      |=> ((pend_all & $past(pend_all)) == $past(pend_all)));

  p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(pend_all & ~msk_all));

  p_fiq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == |(pend_all & ~msk_all & sel_all));

  p_fiq_in_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> irq_o);

  p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i[AW-1:3] == '0) |-> (reg_rdata_o[1:0] == 2'b00));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i[AW-1:4] > (AW-4)'(5)) |-> (reg_rdata_o == '0));

  p_reset_r10: assert property (@(posedge clk)
    !rst_n |-> (!irq_o && !fiq_o));
endmodule

bind banked_irq_ctl banked_irq_ctl_chk #(.BANKS(BANKS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
  .fiq_o(fiq_o), .pend_all(pend_all), .msk_all(msk_all), .sel_all(sel_all)
);

// File: tb/banked_irq_ctl_tb.sv
module banked_irq_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src = '0;
  logic        wr = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  banked_irq_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(rdata, exp, tag);
  endtask

  task automatic t_reset;
    rd_chk(10'h010, 0, "R10 pending0");
    rd_chk(10'h058, 0, "R10 mask2");
    rd_chk(10'h000, 0, "R10 vector");
    chk({31'd0, irq}, 0, "R10 irq");
    chk({31'd0, fiq}, 0, "R10 fiq");
  endtask

  task automatic t_sticky;
    @(negedge clk); src[37] = 1'b1;
    @(negedge clk);
    chk({31'd0, irq}, 1, "R4 irq after source");
    src[37] = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk(10'h014, 32'h20, "R1 R2 sticky bank1 bit5");
    chk({31'd0, irq}, 1, "R2 irq held");
  endtask

  task automatic t_w1c;
    wr_reg(10'h014, 32'h0);
    rd_chk(10'h014, 32'h20, "R3 zero write keeps");
    wr_reg(10'h014, 32'h20);
    rd_chk(10'h014, 32'h0, "R3 one write clears");
    chk({31'd0, irq}, 0, "R4 irq drops after clear");
    @(negedge clk);
    src[70] = 1'b1; wr = 1'b1; addr = 10'h018; wdata = 32'h40;
    @(negedge clk);
    wr = 1'b0; src[70] = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk(10'h018, 32'h40, "R3 set beats clear");
    wr_reg(10'h018, 32'h40);
    rd_chk(10'h018, 32'h0, "R3 cleared after");
  endtask

  task automatic t_mask_fiq;
    wr_reg(10'h050, 32'h8);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); src[3] = 1'b0;
    chk({31'd0, irq}, 0, "R4 masked source");
    wr_reg(10'h050, 32'h0);
    chk({31'd0, irq}, 1, "R4 unmask raises irq");
    chk({31'd0, fiq}, 0, "R5 not selected");
    wr_reg(10'h030, 32'h8);
    chk({31'd0, fiq}, 1, "R5 selected raises fiq");
    wr_reg(10'h040, 32'h0);
    wr_reg(10'h044, 32'hFFFF_FFFF);
    chk({30'd0, irq, fiq}, 2'b11, "R6 enable has no effect");
    wr_reg(10'h050, 32'h8);
    chk({30'd0, irq, fiq}, 2'b00, "R4 R5 mask drops both");
    wr_reg(10'h050, 32'h0);
    wr_reg(10'h010, 32'h8);
    chk({30'd0, irq, fiq}, 2'b00, "R4 R5 clear drops both");
  endtask

  task automatic t_regs;
    wr_reg(10'h000, 32'hFFFF_FFFF);
    rd_chk(10'h000, 32'hFFFF_FFFC, "R7 vector align");
    wr_reg(10'h004, 32'h1234_5677);
    rd_chk(10'h004, 32'h1234_5674, "R7 base align");
    wr_reg(10'h008, 32'hA5A5_0003);
    rd_chk(10'h008, 32'hA5A5_0003, "R6 protect rw");
    wr_reg(10'h00C, 32'h0000_0001);
    rd_chk(10'h00C, 32'h0000_0001, "R6 nmi rw");
    wr_reg(10'h038, 32'hCAFE_0001);
    rd_chk(10'h038, 32'hCAFE_0001, "R1 R6 select bank2");
    rd_chk(10'h044, 32'hFFFF_FFFF, "R6 enable bank1");
    wr_reg(10'h058, 32'h0F0F_0000);
    rd_chk(10'h058, 32'h0F0F_0000, "R6 mask bank2");
  endtask

  task automatic t_fast_pend;
    wr_reg(10'h024, 32'hFFFF_FFFF);
    rd_chk(10'h024, 32'h0, "R8 fast pending zero");
  endtask

  task automatic t_unmapped;
    wr_reg(10'h060, 32'hFFFF_FFFF);
    rd_chk(10'h060, 32'h0, "R9 high offset reads zero");
    wr_reg(10'h03C, 32'hFFFF_FFFF);
    rd_chk(10'h03C, 32'h0, "R9 bank3 reads zero");
    rd_chk(10'h030, 32'h8, "R9 select0 untouched");
    rd_chk(10'h038, 32'hCAFE_0001, "R9 select2 untouched");
    wr_reg(10'h05C, 32'hFFFF_FFFF);
    @(negedge clk); src[1] = 1'b1;
    @(negedge clk); src[1] = 1'b0;
    chk({31'd0, irq}, 1, "R9 mask unchanged");
    wr_reg(10'h010, 32'h2);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1;
    chk({31'd0, irq}, 0, "R10 irq in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_w1c();
    t_mask_fiq();
    t_regs();
    t_fast_pend();
    t_unmapped();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule